// File: doc/BRIEF.md
# Lookup-Table Trigger Engine for a 16-Channel Logic Analyzer

This block decides, sample by sample, whether a 16-channel logic analyzer should trigger. The channels are cut into four groups of four (quads). Each quad's four bits address small 16-entry truth tables. One set of tables gives a level pattern match. Two more sets give edge sources A and B. The current and previous values of A and B then address a 16-entry glue table, which says whether the wanted transition happened. Because all conditions are held as truth tables, one datapath serves level patterns, rising edges, falling edges and mixes of them. Software only has to compute table contents.

Samples arrive on a valid/ready stream. The engine never applies back-pressure after reset: `smp_ready` is low only while reset is held and the first clock after it, and then stays high. A sample counts only in a cycle where both `smp_valid` and `smp_ready` are high. Tables are loaded one address at a time through a byte-wide configuration port. Two staging bytes are written, then a commit byte carries a tag and the table address. The trigger output is a registered flag that stays set until `arm` is pulsed.

Top module: `trig_lut_top`

## Requirements
- R1: Quad q is formed from channels 4q..4q+3, with channel 4q+k driving bit k of that quad's 4-bit table index.
- R2: The level match is the AND of the four match-table entries selected by the quads' indices; a quad whose table is all ones imposes no condition.
- R3: Edge source A and edge source B are each the AND of their own four quad-table lookups, computed the same way as the match.
- R4: The glue index has source A's current value in bit 0, A's previous value in bit 1, B's current value in bit 2 and B's previous value in bit 3; the glue entry at that index gates the trigger, so an all-ones glue table leaves the match alone in control.
- R5: Only accepted samples (`smp_valid` and `smp_ready` both high) are evaluated, and only they replace the stored previous source values; `trig` rises on the clock edge that accepts a sample whose match and glue result are both 1.
- R6: For the first accepted sample after reset, the previous source values are taken equal to the current ones, so no edge is seen on that sample.
- R7: Configuration writes use `cfg_sel`: 0 stages the low byte (bits 0-3 match quads 0-3, bit 4 glue), 1 stages the high byte (bits 0-3 source-A quads 0-3, bits 4-7 source-B quads 0-3), 2 commits. A commit whose `cfg_data[7:4]` equals 3 writes the staged bits into table address `cfg_data[3:0]` of every table; a commit with any other tag changes nothing.
- R8: Low staging byte bits 5 and 6 are accepted but have no effect on any table or on `trig`.
- R9: Once set, `trig` stays high until `arm` is pulsed.
- R10: A cycle with `arm` high clears `trig` unless the same cycle accepts a qualifying sample, in which case `trig` is high afterwards.
- R11: Reset clears `trig` and every table, and holds `smp_ready` low; `smp_ready` is high from the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample word present |
| smp_ready | output | 1 | Engine accepts a sample this cycle |
| smp_data | input | 16 | Channel sample word, channel n on bit n |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 low staging byte, 1 high staging byte, 2 commit |
| cfg_data | input | 8 | Configuration byte |
| arm | input | 1 | Clears the latched trigger |
| trig | output | 1 | Latched trigger flag |

## Verification
The hardest state to reach from the ports is an edge decision where the stored previous values do not come from the current sample history. This happens on the first sample after reset, and on the first sample after the tables are reloaded, when the stored bits still come from the old tables. The bench reaches the first case by resetting and loading a rising-edge program before any sample is offered. It then checks that a high first sample does not trigger. It reaches the second case by walking its vector table straight across program changes without a reset, and it works out each expected value from the source values that the old program left behind. Skipped samples, with `smp_valid` held low, are placed between an edge's two halves, so a design that updated its history on them would miss the edge.

// File: rtl/trig_lut_pkg.sv
package trig_lut_pkg;

  localparam int unsigned DEF_QUADS  = 4;
  localparam int unsigned DEF_QUAD_W = 4;

  typedef enum logic [1:0] {
    CFG_STAGE_LO = 2'd0,
    CFG_STAGE_HI = 2'd1,
    CFG_COMMIT   = 2'd2,
    CFG_RSVD     = 2'd3
  } cfg_sel_e;

  localparam logic [3:0] COMMIT_TAG = 4'h3;

endpackage

// File: rtl/trig_lut_loader.sv
module trig_lut_loader
  import trig_lut_pkg::*;
#(
  parameter int unsigned QUADS  = DEF_QUADS,
  parameter int unsigned QUAD_W = DEF_QUAD_W,
  localparam int unsigned CFG_W = 2 * QUADS,
  localparam int unsigned TAG_W = CFG_W - QUAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              ld_en,
  output logic [QUAD_W-1:0] ld_addr,
  output logic [QUADS-1:0]  ld_match,
  output logic              ld_glue,
  output logic [QUADS-1:0]  ld_src_a,
  output logic [QUADS-1:0]  ld_src_b
);

  // Only the used low-byte bits are kept: match quads plus the glue bit.
  logic [QUADS:0]     stage_lo_q;
  logic [CFG_W-1:0]   stage_hi_q;
  logic               wr_lo, wr_hi, wr_commit;
  logic [TAG_W-1:0]   tag_field;

  assign wr_lo     = cfg_valid && (cfg_sel == CFG_STAGE_LO);
  assign wr_hi     = cfg_valid && (cfg_sel == CFG_STAGE_HI);
  assign wr_commit = cfg_valid && (cfg_sel == CFG_COMMIT);
  assign tag_field = cfg_data[CFG_W-1:QUAD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q <= '0;
      stage_hi_q <= '0;
    end else begin
      if (wr_lo) stage_lo_q <= cfg_data[QUADS:0];
      if (wr_hi) stage_hi_q <= cfg_data;
    end
  end

  always_comb begin
    ld_en    = wr_commit && (tag_field == TAG_W'(COMMIT_TAG));
    ld_addr  = cfg_data[QUAD_W-1:0];
    ld_match = stage_lo_q[QUADS-1:0];
    ld_glue  = stage_lo_q[QUADS];
    ld_src_a = stage_hi_q[QUADS-1:0];
    ld_src_b = stage_hi_q[CFG_W-1:QUADS];
  end

endmodule

// File: rtl/trig_lut_quad_bank.sv
module trig_lut_quad_bank
  import trig_lut_pkg::*;
#(
  parameter int unsigned QUADS  = DEF_QUADS,
  parameter int unsigned QUAD_W = DEF_QUAD_W,
  localparam int unsigned DEPTH = 1 << QUAD_W,
  localparam int unsigned SMP_W = QUADS * QUAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [QUAD_W-1:0] wr_addr,
  input  logic [QUADS-1:0]  wr_bits,
  input  logic [SMP_W-1:0]  smp,
  output logic              hit
);

  logic [QUADS-1:0] look;

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    logic [DEPTH-1:0]  tbl_q;
    logic [QUAD_W-1:0] idx;

    assign idx = smp[q*QUAD_W +: QUAD_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tbl_q          <= '0;
      else if (wr_en) tbl_q[wr_addr] <= wr_bits[q];
    end

    assign look[q] = tbl_q[idx];
  end

  assign hit = &look;

endmodule

// File: rtl/trig_lut_edge_glue.sv
module trig_lut_edge_glue
  import trig_lut_pkg::*;
#(
  parameter int unsigned QUAD_W = DEF_QUAD_W,
  localparam int unsigned DEPTH = 1 << QUAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              cur_a,
  input  logic              cur_b,
  input  logic              wr_en,
  input  logic [QUAD_W-1:0] wr_addr,
  input  logic              wr_bit,
  output logic              edge_ok
);

  logic [DEPTH-1:0] glue_q;
  logic             prev_a_q, prev_b_q, first_q;
  logic             eff_a, eff_b;
  logic [3:0]       gidx;

  // Before any accepted sample, history mirrors the present sample.
  assign eff_a   = first_q ? cur_a : prev_a_q;
  assign eff_b   = first_q ? cur_b : prev_b_q;
  assign gidx    = {eff_b, cur_b, eff_a, cur_a};
  assign edge_ok = glue_q[QUAD_W'(gidx)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glue_q   <= '0;
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
      first_q  <= 1'b1;
    end else begin
      if (wr_en) glue_q[wr_addr] <= wr_bit;
      if (acc) begin
        prev_a_q <= cur_a;
        prev_b_q <= cur_b;
        first_q  <= 1'b0;
      end
    end
  end

  AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(prev_a_q) && $stable(prev_b_q)))
    else $error("history moved without an accepted sample"); // R5

endmodule

// File: rtl/trig_lut_top.sv
module trig_lut_top
  import trig_lut_pkg::*;
#(
  parameter int unsigned QUADS  = DEF_QUADS,
  parameter int unsigned QUAD_W = DEF_QUAD_W,
  localparam int unsigned SMP_W = QUADS * QUAD_W,
  localparam int unsigned CFG_W = 2 * QUADS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             arm,
  output logic             trig
);

  logic              ld_en, ld_glue;
  logic [QUAD_W-1:0] ld_addr;
  logic [QUADS-1:0]  ld_match, ld_src_a, ld_src_b;
  logic              lvl_hit, src_a, src_b, edge_ok;
  logic              acc, ready_q, trig_q;

  assign acc       = smp_valid && ready_q;
  assign smp_ready = ready_q;
  assign trig      = trig_q;

  trig_lut_loader #(.QUADS(QUADS), .QUAD_W(QUAD_W)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_match(ld_match),
    .ld_glue(ld_glue), .ld_src_a(ld_src_a), .ld_src_b(ld_src_b)
  );

  trig_lut_quad_bank #(.QUADS(QUADS), .QUAD_W(QUAD_W)) u_match (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_en), .wr_addr(ld_addr),
    .wr_bits(ld_match), .smp(smp_data), .hit(lvl_hit)
  );

  trig_lut_quad_bank #(.QUADS(QUADS), .QUAD_W(QUAD_W)) u_src_a (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_en), .wr_addr(ld_addr),
    .wr_bits(ld_src_a), .smp(smp_data), .hit(src_a)
  );

  trig_lut_quad_bank #(.QUADS(QUADS), .QUAD_W(QUAD_W)) u_src_b (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_en), .wr_addr(ld_addr),
    .wr_bits(ld_src_b), .smp(smp_data), .hit(src_b)
  );

  trig_lut_edge_glue #(.QUAD_W(QUAD_W)) u_glue (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cur_a(src_a), .cur_b(src_b),
    .wr_en(ld_en), .wr_addr(ld_addr), .wr_bit(ld_glue), .edge_ok(edge_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      trig_q  <= (trig_q && !arm) || (acc && lvl_hit && edge_ok);
    end
  end

  AST_TRIG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !arm) |=> trig_q)
    else $error("trigger dropped without arm"); // R9

  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !acc) |=> !trig_q)
    else $error("arm did not clear trigger"); // R10

  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !$rose(trig_q))
    else $error("trigger rose without an accepted sample"); // R5

  AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !lvl_hit) |=> !$rose(trig_q))
    else $error("trigger rose without a level match"); // R2

  AST_BAD_TAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_sel == CFG_COMMIT && cfg_data[CFG_W-1:QUAD_W] != 4'h3)
      |-> !ld_en)
    else $error("commit with wrong tag wrote tables"); // R7

endmodule

// File: tb/trig_lut_top_tb.sv
`timescale 1ns/1ps
module trig_lut_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        arm = 1'b0;
  logic        trig;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trig_lut_top u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .arm(arm), .trig(trig)
  );

  // {program id[2:0], arm, sample[15:0], expected trig}
  localparam int NV = 22;
  localparam logic [20:0] VEC [NV] = '{
    {3'd1, 1'b1, 16'h0001, 1'b1}, {3'd1, 1'b1, 16'h0000, 1'b0},
    {3'd1, 1'b1, 16'h0021, 1'b0}, {3'd1, 1'b1, 16'hFFDF, 1'b1},
    {3'd1, 1'b1, 16'h0000, 1'b0}, {3'd1, 1'b0, 16'h0001, 1'b1},
    {3'd1, 1'b0, 16'h0000, 1'b1},
    {3'd2, 1'b1, 16'h0000, 1'b0}, {3'd2, 1'b1, 16'h0200, 1'b1},
    {3'd2, 1'b1, 16'h0200, 1'b0}, {3'd2, 1'b1, 16'h0000, 1'b0},
    {3'd2, 1'b1, 16'hFDFF, 1'b0}, {3'd2, 1'b1, 16'hFFFF, 1'b1},
    {3'd3, 1'b1, 16'hFFFF, 1'b0}, {3'd3, 1'b1, 16'hBFFF, 1'b1},
    {3'd3, 1'b1, 16'h0000, 1'b0}, {3'd3, 1'b1, 16'h4000, 1'b0},
    {3'd3, 1'b1, 16'h0000, 1'b1},
    {3'd4, 1'b1, 16'h0000, 1'b0}, {3'd4, 1'b1, 16'h0200, 1'b0},
    {3'd4, 1'b1, 16'h0001, 1'b0}, {3'd4, 1'b1, 16'h0201, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Quad table for a value/mask condition: entry j is 1 when every masked
  // channel of quad q equals its required value under index j.
  function automatic logic [15:0] quad_tbl(input logic [15:0] val,
                                           input logic [15:0] msk,
                                           input int q);
    logic [15:0] t = '1;
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 4; k++)
        if (msk[4*q+k] && (val[4*q+k] != j[k])) t[j] = 1'b0;
    return t;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    cfg_valid = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_sel = '0; cfg_data = '0;
  endtask

  task automatic load_prog(input int id);
    logic [15:0] mv, mm, av, am, bv, bm, glue;
    logic [7:0]  lo, hi;
    case (id)
      1: begin mv = 16'h0001; mm = 16'h0021; av = 0; am = 0; bv = 0; bm = 0; glue = 16'hFFFF; end
      2: begin mv = 0; mm = 0; av = 16'h0200; am = 16'h0200; bv = 0; bm = 0; glue = 16'h2222; end
      3: begin mv = 0; mm = 0; av = 0; am = 0; bv = 16'h4000; bm = 16'h4000; glue = 16'h0F00; end
      default: begin mv = 16'h0001; mm = 16'h0001; av = 16'h0200; am = 16'h0200; bv = 0; bm = 0; glue = 16'h2222; end
    endcase
    for (int i = 0; i < 16; i++) begin
      lo = 8'h60;  // R8: bits 5 and 6 set on every load, must not matter
      hi = 8'h00;
      for (int q = 0; q < 4; q++) begin
        lo[q]   = quad_tbl(mv, mm, q)[i];
        hi[q]   = quad_tbl(av, am, q)[i];
        hi[4+q] = quad_tbl(bv, bm, q)[i];
      end
      lo[4] = glue[i];
      cfg_write(2'd0, lo);
      cfg_write(2'd1, hi);
      cfg_write(2'd2, {4'h3, 4'(i)});
    end
  endtask

  // Drive one cycle at a falling edge; after the next falling edge the
  // registered trigger reflects it.
  task automatic step(input logic v, input logic [15:0] d, input logic a);
    smp_valid = v; smp_data = d; arm = a;
    @(negedge clk);
    smp_valid = 1'b0; arm = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cur_prog = 0;
    @(negedge clk); @(negedge clk);
    check("R11 reset trig", trig, 1'b0);
    check("R11 reset ready", smp_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", smp_ready, 1'b1);
    step(1'b1, 16'hFFFF, 1'b0);
    check("R11 cleared tables give no trigger", trig, 1'b0);

    // Vector walk across program changes (R1-R5, R8, R9, R10)
    for (int n = 0; n < NV; n++) begin
      if (int'(VEC[n][20:18]) != cur_prog) begin
        cur_prog = int'(VEC[n][20:18]);
        load_prog(cur_prog);
      end
      step(1'b1, VEC[n][16:1], VEC[n][17]);
      check($sformatf("R1 R2 R3 R4 R9 R10 vector %0d", n), trig, VEC[n][0]);
    end

    // R6: first accepted sample after reset sees no edge
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    load_prog(2);
    step(1'b1, 16'h0200, 1'b0);
    check("R6 no edge on first sample", trig, 1'b0);
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'h0200, 1'b0);
    check("R6 edge after first sample", trig, 1'b1);
    step(1'b0, 16'h0000, 1'b1);
    check("R10 arm clears latched trigger", trig, 1'b0);

    // R5: unaccepted samples neither trigger nor move the history
    step(1'b1, 16'h0000, 1'b0);
    step(1'b0, 16'h0200, 1'b0);
    check("R5 invalid sample no trigger", trig, 1'b0);
    step(1'b1, 16'h0200, 1'b0);
    check("R5 history kept across invalid sample", trig, 1'b1);

    // R7: wrong commit tag ignored, right tag writes the address
    load_prog(1);
    cfg_write(2'd0, 8'h00);
    cfg_write(2'd1, 8'h00);
    cfg_write(2'd2, 8'h21);
    step(1'b1, 16'h0001, 1'b1);
    check("R7 wrong tag ignored", trig, 1'b1);
    cfg_write(2'd2, 8'h31);
    step(1'b1, 16'h0001, 1'b1);
    check("R7 tagged commit writes address", trig, 1'b0);
    step(1'b1, 16'h0003, 1'b1);
    check("R7 other address untouched", trig, 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule